// File: doc/BRIEF.md
# Overlapping 101 Serial Pattern Detector

This block watches a one-bit serial stream and raises a flag when the three most recent samples, oldest first, are 1, 0, 1. One new bit is taken on every rising clock edge. The upstream driver is expected to change the input on the falling edge, so the value is stable when it is sampled. There is no handshake: every clock cycle consumes exactly one bit, and the stream cannot be stalled.

It is a Moore machine. It does not keep a window of raw bits. Instead it keeps a two-bit progress code that records how much of the pattern is currently matched. The flag is decoded from that code alone, so it rises just after the clock edge that samples the completing 1 and stays high for one full clock period. Matches may overlap, so a stream of 1,0,1,0,1 raises the flag twice. A synchronous, active-high reset returns the machine to the idle code.

Top module: `det101_detector`

## Requirements
- R1: When `rst` is high at a rising edge, the state becomes idle (code 00) and `match_out` is 0 for the following cycle, whatever `bit_in` is.
- R2: After the rising edge that samples the third bit of the sequence 1,0,1, `match_out` is 1 for exactly one clock period. Two consecutive cycles never both show a match.
- R3: Matches overlap. The final 1 of a match counts as the first 1 of the next match, so the stream 1,0,1,0,1 produces two pulses, two cycles apart.
- R4: The progress code is idle=00, got "1"=01, got "10"=10, got "101"=11. Code bit 0 takes the sampled bit. Code bit 1 takes (bit0 AND NOT x) OR (bit1 AND NOT bit0 AND x). `match_out` is 1 only in code 11.
- R5: No other three-bit window produces a pulse. This covers 111, 011, 001, 100 and 110, and also 1,0,0 followed by 1.
- R6: A reset in the middle of a sequence discards any partial match. Bits sampled before the reset never complete a pattern.
- R7: For any input stream, `match_out` equals the check "the last three bits sampled since reset are 1,0,1".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `bit_in` is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the idle code |
| bit_in | input | 1 | Serial data bit, one per cycle |
| match_out | output | 1 | High for one period after 1,0,1 has been seen |

## Verification
The bench targets the overlap case 1,0,1,0,1. A design that returned to idle after a match would show only one pulse there. The bench also drives runs of 1s and the sequence 1,0,0,1. A design that recovered to the wrong state would pulse on 1,1,0,1 too late, or would pulse falsely after 1,0,0,1. It asserts reset right after a partial 1,0 and then feeds a 1. A design whose reset cleared only the output, and not the progress code, would pulse there. Finally, a long random stream is compared against a three-bit history model, which exposes any wrong term in the next-state equations.

// File: rtl/det101_pkg.sv
package det101_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 2'b00,
    ST_GOT1   = 2'b01,
    ST_GOT10  = 2'b10,
    ST_GOT101 = 2'b11
  } det_state_e;
endpackage

// File: rtl/det101_next.sv
module det101_next
  import det101_pkg::*;
(
  input  det_state_e cur_i,
  input  logic       x_i,
  output det_state_e nxt_o
);
  logic q1, q0, d1, d0;

  always_comb begin
    q1 = cur_i[1];
    q0 = cur_i[0];
    // progress bit 0 tracks the newest sample; bit 1 marks "a 0 follows a 1"
    d0 = x_i;
    d1 = (q0 & ~x_i) | (q1 & ~q0 & x_i);
    nxt_o = det_state_e'({d1, d0});
  end
endmodule

// File: rtl/det101_state_reg.sv
module det101_state_reg
  import det101_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  det_state_e nxt_i,
  output det_state_e cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= ST_IDLE;
    else     cur_o <= nxt_i;
  end
endmodule

// File: rtl/det101_out.sv
module det101_out
  import det101_pkg::*;
(
  input  det_state_e cur_i,
  output logic       hit_o
);
  always_comb hit_o = cur_i[1] & cur_i[0];
endmodule

// File: rtl/det101_detector.sv
module det101_detector
  import det101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic match_out
);
  det_state_e state_q;
  det_state_e state_d;

  det101_next u_next (
    .cur_i (state_q),
    .x_i   (bit_in),
    .nxt_o (state_d)
  );

  det101_state_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (state_d),
    .cur_o (state_q)
  );

  det101_out u_out (
    .cur_i (state_q),
    .hit_o (match_out)
  );
endmodule

// File: rtl/det101_checker.sv
module det101_checker
  import det101_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_in,
  input logic       match_out,
  input det_state_e state_q
);
  // R1: reset yields idle and no match on the next cycle
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE) && !match_out);

  // R2: a pulse never lasts more than one period
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    match_out |=> !match_out);

  // R3: after a match, a 0 keeps "10" progress for the overlap
  assert_overlap_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (match_out && !bit_in) |=> (state_q == ST_GOT10));

  // R4: from "1", a 0 advances to "10"
  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_GOT1) && !bit_in) |=> (state_q == ST_GOT10));

  // R5: a pulse is only possible when the last sampled bit was 1
  assert_last_one_R5: assert property (@(posedge clk) disable iff (rst)
    (!bit_in) |=> !match_out);
endmodule

bind det101_detector det101_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_in    (bit_in),
  .match_out (match_out),
  .state_q   (state_q)
);

// File: tb/det101_detector_tb_top.sv
`timescale 1ns/1ps
module det101_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic match_out;

  int vectors = 0;
  int miscompares = 0;
  logic [2:0] hist;

  always #4 clk = ~clk; // 125 MHz

  det101_detector dut_i (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .match_out (match_out)
  );

  // {rst, bit, expected match}
  localparam int NV = 18;
  localparam logic [2:0] VEC [NV] = '{
    3'b100, // R1 reset
    3'b010, 3'b000, 3'b011, // R2 first 101
    3'b000, 3'b011,         // R3 overlap 10101
    3'b010, 3'b010, 3'b000, 3'b000, // R5 1,1,0,0
    3'b010, 3'b000,         // partial 10
    3'b110,                 // R6 reset mid-sequence with bit 1
    3'b000, 3'b010, 3'b000, 3'b011, // R4 clean 0,1,0,1
    3'b010                  // R2 pulse ends
  };

  task automatic step(input logic r, input logic b, input logic e, input string req);
    @(negedge clk);
    rst = r;
    bit_in = b;
    @(posedge clk);
    #2;
    vectors++;
    if (match_out !== e) begin
      miscompares++;
      $display("FAIL %s: match_out=%b expected=%b (rst=%b bit=%b)", req, match_out, e, r, b);
    end
  endtask

  task automatic model_step(input logic r, input logic b);
    logic e;
    if (r) hist = 3'b000;
    else   hist = {hist[1:0], b};
    e = !r && (hist == 3'b101);
    step(r, b, e, "R7");
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) step(VEC[i][2], VEC[i][1], VEC[i][0], "R2/R3/R4/R6 table");

    // R1: reset while a match is showing
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, 1'b0, "R1");
    // R5: 1,0,0,1 must not pulse; 1,1,0,1 pulses once
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b1, "R5");
    // R3: long alternating run pulses every other bit
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b1, "R3");

    // R7: random stream against a history model, with occasional resets
    hist = 3'b000;
    model_step(1'b1, 1'b0);
    for (int i = 0; i < 1500; i++) begin
      logic r;
      r = ($urandom_range(0, 99) == 0);
      model_step(r, 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule